// File: doc/BRIEF.md
# Processor Presence Bitmap and Hot-Plug Event Controller

This block keeps one presence bit for every processor ID in the system and tells the operating system when a processor comes or goes. Platform logic issues a plug or unplug request that carries a processor ID. The block sets or clears the matching bit and latches a processor hot-plug event flag in a general-purpose event status byte. A second flag in the same byte latches the PCI hot-plug event. Each status flag is paired with a bit in an enable byte. The interrupt line to the OS is a registered level. It is raised when any enabled hot-plug flag is pending or when the external fixed-event summary is active.

Software reaches the block through a byte-wide I/O port with a simple request/acknowledge handshake. A 32-byte read-only window exposes the bitmap: window byte N holds IDs 8N to 8N+7, and ID k sits in bit k%8. Two further byte addresses hold the event status, which software clears by writing ones, and the event enable. The bitmap is loaded at reset from a parameter that lists the processors present at boot.

An access FSM has two states. BUS_IDLE accepts a request (transition IDLE->ACK on `io_req`). BUS_ACK presents the acknowledge and read data for one cycle (transition ACK->IDLE, unconditional).

Top module: `cpuhp_ctrl`

## Requirements
- R1: After reset the bitmap equals the boot map (default: IDs 0 and 1 present, so window byte 0 reads 0x03 and the other bytes read 0x00). The status byte, the enable byte and `sci` are all 0.
- R2: A read at address 0xAF00+N (N = 0..31) returns bitmap byte N, where processor ID k is bit k%8 of byte k/8.
- R3: Writes to addresses 0xAF00..0xAF1F are acknowledged and have no effect on the bitmap.
- R4: A request with `hp_plug`=1 sets the bit of `hp_id`, and a request with `hp_plug`=0 clears it. The bit changes on the clock edge that samples `hp_valid`.
- R5: Every accepted plug or unplug request sets status bit 2 (mask 0x04, status byte at address 0xAF20). This holds even when the bitmap bit already had the requested value, and when status bit 2 was already set.
- R6: A request with `hp_id` of 256 or above changes no bitmap bit, including the bit its low eight bits would alias to, and raises no status bit.
- R7: A one-cycle pulse on `pci_evt` sets status bit 1 (mask 0x02).
- R8: Writing the status byte clears each bit written as 1 and leaves each bit written as 0. A hardware set in the same cycle as a clear of the same bit leaves the bit set. The enable byte at address 0xAF21 is read/write.
- R9: `sci` is registered. It equals `fixed_evt` OR ((status AND enable AND 0x06) != 0), as evaluated one clock before it.
- R10: Each accepted access gives `io_ack` high for exactly one cycle, the cycle after acceptance. `io_rdata` is valid in that cycle. Addresses outside the window and the two registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_valid | input | 1 | Plug/unplug request strobe |
| hp_plug | input | 1 | 1 = plug (set bit), 0 = unplug (clear bit) |
| hp_id | input | 9 | Processor ID of the request |
| pci_evt | input | 1 | PCI hot-plug event pulse |
| fixed_evt | input | 1 | Summary of active fixed-event status/enable pairs |
| io_req | input | 1 | I/O access request, taken in BUS_IDLE |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Byte address |
| io_wdata | input | 8 | Write data |
| io_ack | output | 1 | Access acknowledge, one cycle |
| io_rdata | output | 8 | Read data, valid with io_ack |
| sci | output | 1 | Level interrupt to the OS |

## Verification
Plugs and unplugs are directed at IDs in the first byte, in a middle byte and at the highest ID, 255. This separates the byte selection from the bit selection and exposes reversed or shifted lanes. Repeated plugs of a present ID show that the event flag is raised independently of whether the bitmap changed. An ID of 300 shows that out-of-range requests neither alias into byte 5 nor flag an event. A clear that coincides with a request tells set-priority apart from clear-priority. Toggling the enable byte, the PCI pulse and the fixed-event input, with `sci` sampled one and two cycles later, pins the interrupt latency and shows which status bits feed the interrupt.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    localparam int GPE_PCI_BIT = 1;
    localparam int GPE_CPU_BIT = 2;
    localparam logic [7:0] GPE_HP_MASK = 8'h06;

endpackage

// File: rtl/cpuhp_map.sv
module cpuhp_map #(
    parameter int NUM_IDS = 256,
    parameter int REQ_ID_W = 9,
    parameter logic [NUM_IDS-1:0] BOOT_MAP = '0,
    localparam int NUM_BYTES = NUM_IDS / 8,
    localparam int OFF_W = $clog2(NUM_BYTES),
    localparam int IDX_W = $clog2(NUM_IDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_plug,
    input  logic [REQ_ID_W-1:0] req_id,
    input  logic [OFF_W-1:0]    rd_off,
    output logic [7:0]          rd_byte,
    output logic                req_ok
);

    logic [NUM_IDS-1:0] map_q;
    logic [7:0]         byte_arr [NUM_BYTES];
    logic [IDX_W-1:0]   idx;
    logic               in_range;

    assign in_range = (req_id < REQ_ID_W'(NUM_IDS));
    assign req_ok   = req_valid && in_range;
    assign idx      = req_id[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= BOOT_MAP;
        end else if (req_ok) begin
            map_q[idx] <= req_plug;
        end
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_bytes
        assign byte_arr[g] = map_q[g*8 +: 8];
    end

    assign rd_byte = byte_arr[rd_off];

    // R4
    plug_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_range && req_plug) |=> map_q[$past(idx)]);

    // R4
    unplug_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_range && !req_plug) |=> !map_q[$past(idx)]);

    // R6
    range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_range) |=> $stable(map_q));

endmodule

// File: rtl/cpuhp_gpe.sv
module cpuhp_gpe
    import cpuhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_evt,
    input  logic       pci_evt,
    input  logic       fixed_evt,
    input  logic [7:0] sts_clr,
    input  logic       en_we,
    input  logic [7:0] en_wdata,
    output logic [7:0] sts,
    output logic [7:0] en,
    output logic       sci
);

    logic [7:0] sts_q;
    logic [7:0] en_q;
    logic       sci_q;
    logic [7:0] set_vec;
    logic       pending;

    always_comb begin
        set_vec = '0;
        set_vec[GPE_CPU_BIT] = cpu_evt;
        set_vec[GPE_PCI_BIT] = pci_evt;
    end

    assign pending = |(sts_q & en_q & GPE_HP_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            sci_q <= 1'b0;
        end else begin
            sts_q <= (sts_q & ~sts_clr) | set_vec;
            if (en_we) begin
                en_q <= en_wdata;
            end
            sci_q <= fixed_evt || pending;
        end
    end

    assign sts = sts_q;
    assign en  = en_q;
    assign sci = sci_q;

    // R5
    cpu_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_evt |=> sts_q[GPE_CPU_BIT]);

    // R7
    pci_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_evt |=> sts_q[GPE_PCI_BIT]);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[GPE_CPU_BIT] && !sts_clr[GPE_CPU_BIT]) |=> sts_q[GPE_CPU_BIT]);

    // R9
    sci_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[GPE_CPU_BIT] && en_q[GPE_CPU_BIT]) |=> sci_q);

    // R9
    sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fixed_evt && !(|(sts_q & en_q))) |=> !sci_q);

endmodule

// File: rtl/cpuhp_io.sv
module cpuhp_io
    import cpuhp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_BYTES = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hAF00,
    parameter logic [ADDR_W-1:0] STS_ADDR = 16'hAF20,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 16'hAF21,
    localparam int OFF_W = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic [7:0]        win_byte,
    input  logic [7:0]        sts,
    input  logic [7:0]        en,
    output logic [OFF_W-1:0]  win_off,
    output logic [7:0]        sts_clr,
    output logic              en_we,
    output logic [7:0]        en_wdata,
    output logic              io_ack,
    output logic [7:0]        io_rdata
);

    bus_state_e        state_q;
    bus_state_e        state_n;
    logic              accept;
    logic [ADDR_W-1:0] rel;
    logic              win_hit;
    logic [7:0]        rd_sel;
    logic [7:0]        rdata_q;

    assign accept  = (state_q == BUS_IDLE) && io_req;
    assign rel     = io_addr - WIN_BASE;
    assign win_hit = (rel < ADDR_W'(NUM_BYTES));
    assign win_off = rel[OFF_W-1:0];

    always_comb begin
        if (win_hit) begin
            rd_sel = win_byte;
        end else if (io_addr == STS_ADDR) begin
            rd_sel = sts;
        end else if (io_addr == EN_ADDR) begin
            rd_sel = en;
        end else begin
            rd_sel = '0;
        end
    end

    assign sts_clr  = (accept && io_wr && io_addr == STS_ADDR) ? io_wdata : 8'h00;
    assign en_we    = accept && io_wr && (io_addr == EN_ADDR);
    assign en_wdata = io_wdata;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            BUS_IDLE: if (io_req) state_n = BUS_ACK;
            BUS_ACK:  state_n = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= io_wr ? 8'h00 : rd_sel;
        end
    end

    assign io_ack   = (state_q == BUS_ACK);
    assign io_rdata = rdata_q;

    // R10
    ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> io_ack);

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |=> !io_ack);

endmodule

// File: rtl/cpuhp_ctrl.sv
module cpuhp_ctrl #(
    parameter int NUM_IDS = 256,
    parameter int REQ_ID_W = 9,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hAF00,
    parameter logic [ADDR_W-1:0] STS_ADDR = 16'hAF20,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 16'hAF21,
    parameter logic [NUM_IDS-1:0] BOOT_MAP = NUM_IDS'(3)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hp_valid,
    input  logic                hp_plug,
    input  logic [REQ_ID_W-1:0] hp_id,
    input  logic                pci_evt,
    input  logic                fixed_evt,
    input  logic                io_req,
    input  logic                io_wr,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [7:0]          io_wdata,
    output logic                io_ack,
    output logic [7:0]          io_rdata,
    output logic                sci
);

    localparam int NUM_BYTES = NUM_IDS / 8;
    localparam int OFF_W = $clog2(NUM_BYTES);

    logic [OFF_W-1:0] win_off;
    logic [7:0]       win_byte;
    logic             req_ok;
    logic [7:0]       sts;
    logic [7:0]       en;
    logic [7:0]       sts_clr;
    logic             en_we;
    logic [7:0]       en_wdata;

    cpuhp_map #(
        .NUM_IDS  (NUM_IDS),
        .REQ_ID_W (REQ_ID_W),
        .BOOT_MAP (BOOT_MAP)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (hp_valid),
        .req_plug  (hp_plug),
        .req_id    (hp_id),
        .rd_off    (win_off),
        .rd_byte   (win_byte),
        .req_ok    (req_ok)
    );

    cpuhp_gpe u_gpe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_evt   (req_ok),
        .pci_evt   (pci_evt),
        .fixed_evt (fixed_evt),
        .sts_clr   (sts_clr),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .sts       (sts),
        .en        (en),
        .sci       (sci)
    );

    cpuhp_io #(
        .ADDR_W    (ADDR_W),
        .NUM_BYTES (NUM_BYTES),
        .WIN_BASE  (WIN_BASE),
        .STS_ADDR  (STS_ADDR),
        .EN_ADDR   (EN_ADDR)
    ) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_req   (io_req),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .win_byte (win_byte),
        .sts      (sts),
        .en       (en),
        .win_off  (win_off),
        .sts_clr  (sts_clr),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .io_ack   (io_ack),
        .io_rdata (io_rdata)
    );

    // R6
    range_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && hp_id >= REQ_ID_W'(NUM_IDS)) |-> !req_ok);

endmodule

// File: tb/cpuhp_ctrl_bench.sv
module cpuhp_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hp_valid = 1'b0;
    logic       hp_plug = 1'b0;
    logic [8:0] hp_id = '0;
    logic       pci_evt = 1'b0;
    logic       fixed_evt = 1'b0;
    logic       io_req = 1'b0;
    logic       io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       io_ack;
    logic [7:0] io_rdata;
    logic       sci;

    int checks = 0;
    int failures = 0;
    logic sci_at_ack;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    cpuhp_ctrl u_cpuhp_ctrl (
        .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_plug(hp_plug),
        .hp_id(hp_id), .pci_evt(pci_evt), .fixed_evt(fixed_evt),
        .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_ack(io_ack), .io_rdata(io_rdata), .sci(sci)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        io_req = 1'b1; io_wr = 1'b0; io_addr = a;
        @(negedge clk);
        chk("R10 ack on read", io_ack, 1);
        d = io_rdata;
        io_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] v);
        io_req = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = v;
        @(negedge clk);
        sci_at_ack = sci;
        io_req = 1'b0; io_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic hp(input logic plug, input logic [8:0] id);
        hp_valid = 1'b1; hp_plug = plug; hp_id = id;
        @(negedge clk);
        hp_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 sci after reset", sci, 0);
        io_read(16'hAF00, d); chk("R1 byte0 boot", d, 8'h03);
        io_read(16'hAF01, d); chk("R1 byte1 boot", d, 8'h00);
        io_read(16'hAF20, d); chk("R1 status reset", d, 8'h00);
        io_read(16'hAF21, d); chk("R1 enable reset", d, 8'h00);
    endtask

    task automatic t_plug;
        logic [7:0] d;
        hp(1'b1, 9'd9);
        io_read(16'hAF01, d); chk("R4 R2 plug id9", d, 8'h02);
        hp(1'b1, 9'd255);
        io_read(16'hAF1F, d); chk("R2 plug id255", d, 8'h80);
        hp(1'b0, 9'd0);
        io_read(16'hAF00, d); chk("R4 unplug id0", d, 8'h02);
        io_read(16'hAF20, d); chk("R5 cpu flag", d, 8'h04);
    endtask

    task automatic t_win_write;
        logic [7:0] d;
        io_write(16'hAF01, 8'hFF);
        io_read(16'hAF01, d); chk("R3 write ignored b1", d, 8'h02);
        io_write(16'hAF00, 8'h00);
        io_read(16'hAF00, d); chk("R3 write ignored b0", d, 8'h02);
    endtask

    task automatic t_range;
        logic [7:0] d;
        io_write(16'hAF20, 8'h04);
        io_read(16'hAF20, d); chk("R8 w1c clears", d, 8'h00);
        hp(1'b1, 9'd300);
        io_read(16'hAF20, d); chk("R6 no event", d, 8'h00);
        io_read(16'hAF05, d); chk("R6 no alias", d, 8'h00);
    endtask

    task automatic t_repeat;
        logic [7:0] d;
        hp(1'b1, 9'd9);
        io_read(16'hAF01, d); chk("R5 bitmap unchanged", d, 8'h02);
        io_read(16'hAF20, d); chk("R5 flag on no-change", d, 8'h04);
        hp(1'b1, 9'd9);
        io_read(16'hAF20, d); chk("R5 flag stays set", d, 8'h04);
    endtask

    task automatic t_w1c;
        logic [7:0] d;
        io_write(16'hAF20, 8'h00);
        io_read(16'hAF20, d); chk("R8 zero leaves", d, 8'h04);
        hp_valid = 1'b1; hp_plug = 1'b1; hp_id = 9'd1;
        io_req = 1'b1; io_wr = 1'b1; io_addr = 16'hAF20; io_wdata = 8'h04;
        @(negedge clk);
        hp_valid = 1'b0; io_req = 1'b0; io_wr = 1'b0;
        @(negedge clk);
        io_read(16'hAF20, d); chk("R8 set wins", d, 8'h04);
        io_write(16'hAF20, 8'h04);
        io_read(16'hAF20, d); chk("R8 cleared", d, 8'h00);
    endtask

    task automatic t_pci;
        logic [7:0] d;
        pci_evt = 1'b1;
        @(negedge clk);
        pci_evt = 1'b0;
        io_read(16'hAF20, d); chk("R7 pci flag", d, 8'h02);
        io_write(16'hAF20, 8'h02);
    endtask

    task automatic t_sci;
        logic [7:0] d;
        hp(1'b1, 9'd2);
        @(negedge clk);
        chk("R9 masked by enable", sci, 0);
        io_write(16'hAF21, 8'h04);
        chk("R9 sci one cycle late", sci_at_ack, 0);
        chk("R9 sci after enable", sci, 1);
        io_read(16'hAF21, d); chk("R8 enable readback", d, 8'h04);
        io_write(16'hAF20, 8'h04);
        chk("R9 sci drops", sci, 0);
        hp(1'b0, 9'd2);
        chk("R9 latency cycle0", sci, 0);
        @(negedge clk);
        chk("R9 latency cycle1", sci, 1);
        io_write(16'hAF20, 8'h04);
        io_write(16'hAF21, 8'h00);
        fixed_evt = 1'b1;
        @(negedge clk);
        chk("R9 fixed event", sci, 1);
        fixed_evt = 1'b0;
        @(negedge clk);
        chk("R9 fixed released", sci, 0);
        io_write(16'hAF21, 8'h02);
        pci_evt = 1'b1;
        @(negedge clk);
        pci_evt = 1'b0;
        @(negedge clk);
        chk("R9 pci enabled", sci, 1);
        io_write(16'hAF20, 8'h02);
    endtask

    task automatic t_bus;
        logic [7:0] d;
        io_req = 1'b1; io_wr = 1'b0; io_addr = 16'hAF40;
        @(negedge clk);
        chk("R10 ack high", io_ack, 1);
        chk("R10 unmapped zero", io_rdata, 8'h00);
        io_req = 1'b0;
        @(negedge clk);
        chk("R10 ack one cycle", io_ack, 0);
        io_read(16'hAF2F, d); chk("R10 gap reads zero", d, 8'h00);
        io_read(16'hAEFF, d); chk("R10 below window zero", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plug();
        t_win_write();
        t_range();
        t_repeat();
        t_w1c();
        t_pci();
        t_sci();
        t_bus();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule